// File: doc/BRIEF.md
# ADC Sampling Front-End Controller

This block connects a parallel 10-bit analog-to-digital converter to a 16-bit slave bus. The bus uses a 2-bit word address and a CYC/STB/WE/ACK handshake. A single configuration register controls the converter clock, the converter sleep pin and the converter chip-select pin. The converter clock comes either straight from the bus clock or from a programmable divide-by-2(N+1) stage. Converted samples are registered one bus cycle after each rising edge of the converter clock. A new-sample flag tells the reader when a fresh sample is present, and reading the sample clears the flag.

The block runs entirely in the bus clock domain. The nominal bus clock is 40 MHz. A host programs the register at word 0 and polls the sample at word 1.

Top module: `adc_frontend_ctrl`

## Requirements
- R1: After reset the configuration register reads 16'h0A00. The converter clock is then the bus clock divided by 2, sleep is 0, chip-select is 1 and ACK is 0.
- R2: ACK is high for exactly one cycle per request, in the cycle after CYC and STB are first seen high together. It stays low while STB remains high after that ACK.
- R3: A write to word 0 stores data bits 11..0. Bits 15..12 are ignored and always read back as 0.
- R4: When configuration bit 9 is 0 (bypass), the converter clock has the same period as the bus clock.
- R5: When bit 9 is 1, the converter clock period is 2*(P+1) bus cycles and it is high for P+1 cycles, where P is bits 8..0.
- R6: The sleep output equals configuration bit 10 and the chip-select output equals configuration bit 11.
- R7: A read of word 1 returns the last sample in bits 9..0, the new-sample flag in bit 15, and 0 in bits 14..10.
- R8: Reading word 1 clears the new-sample flag. The next capture sets it again, and a capture in the same cycle as the read wins.
- R9: With the divider on, the captured sample is the converter data present at the bus-clock edge that follows the edge on which the converter clock rose.
- R10: Words 2 and 3 read as 0. Writes to them leave the configuration register unchanged.
- R11: Every write to word 0 restarts the divider. In divided mode the converter clock is low right after the write edge and first rises P+1 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_i | input | 1 | Bus cycle active |
| stb_i | input | 1 | Bus strobe |
| we_i | input | 1 | Write enable |
| adr_i | input | 2 | Word address |
| dat_i | input | 16 | Write data |
| dat_o | output | 16 | Read data, valid while ack_o is high |
| ack_o | output | 1 | Single-cycle acknowledge |
| adc_data_i | input | 10 | Converter sample data |
| adc_clk_o | output | 1 | Converter clock |
| adc_sleep_o | output | 1 | Converter sleep control |
| adc_cs_o | output | 1 | Converter chip-select control |

## Verification
The assertions assume a master that keeps CYC high together with STB and drops STB after each ACK. The bench's bus tasks follow that rule, lowering STB at most a few cycles after the ACK. The assertions also assume converter data that is stable around each bus-clock edge. The bench therefore changes adc_data_i only on falling clock edges, so the value a capture sees is always known. Divider periods are swept over every prescaler value from 0 to 15, plus the largest value.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;
  localparam int unsigned BUS_W  = 16;
  localparam int unsigned ADR_W  = 2;
  localparam int unsigned SMP_W  = 10;
  localparam int unsigned PRE_W  = 9;
  localparam int unsigned EN_BIT  = PRE_W;
  localparam int unsigned SLP_BIT = PRE_W + 1;
  localparam int unsigned CS_BIT  = PRE_W + 2;
  localparam int unsigned CFG_USED = PRE_W + 3;
  localparam logic [BUS_W-1:0] CFG_RST = 16'h0A00;

  typedef enum logic [ADR_W-1:0] {
    W_CFG  = 2'd0,
    W_SMP  = 2'd1,
    W_RES2 = 2'd2,
    W_RES3 = 2'd3
  } word_e;
endpackage

// File: rtl/adc_fe_clkdiv.sv
module adc_fe_clkdiv
  import adc_fe_pkg::*;
#(
  parameter int unsigned PW = PRE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [PW-1:0] pre_i,
  input  logic          restart_i,
  output logic          adc_clk_o,
  output logic          rise_o
);
  logic [PW-1:0] cnt_q;
  logic          div_q;
  logic          rise_q;
  logic          hit;

  assign hit = (cnt_q == pre_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      div_q  <= 1'b0;
      rise_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q  <= '0;
      div_q  <= 1'b0;
      rise_q <= 1'b0;
    end else if (!en_i) begin
      // bypass: every bus edge is a converter edge
      cnt_q  <= '0;
      div_q  <= 1'b0;
      rise_q <= 1'b1;
    end else begin
      rise_q <= hit & ~div_q;
      if (hit) begin
        cnt_q <= '0;
        div_q <= ~div_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign adc_clk_o = en_i ? div_q : clk_i;
  assign rise_o    = rise_q;

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q <= pre_i));
  p_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0 && !div_q));
  p_rise_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_q && en_i) |-> div_q);
endmodule

// File: rtl/adc_fe_capture.sv
module adc_fe_capture
  import adc_fe_pkg::*;
#(
  parameter int unsigned SW = SMP_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_i,
  input  logic          clr_i,
  input  logic [SW-1:0] adc_data_i,
  output logic [SW-1:0] smp_o,
  output logic          new_o
);
  logic [SW-1:0] smp_q;
  logic          new_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q <= '0;
      new_q <= 1'b0;
    end else if (rise_i) begin
      smp_q <= adc_data_i;
      new_q <= 1'b1;
    end else if (clr_i) begin
      new_q <= 1'b0;
    end
  end

  assign smp_o = smp_q;
  assign new_o = new_q;

  p_flag_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> new_q);
  p_flag_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !rise_i) |=> !new_q);
  p_sample_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> (smp_q == $past(adc_data_i)));
endmodule

// File: rtl/adc_fe_regs.sv
module adc_fe_regs
  import adc_fe_pkg::*;
#(
  parameter int unsigned DW = BUS_W,
  parameter int unsigned AW = ADR_W,
  parameter int unsigned SW = SMP_W,
  parameter int unsigned UW = CFG_USED,
  parameter logic [DW-1:0] RST_VAL = CFG_RST
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cyc_i,
  input  logic          stb_i,
  input  logic          we_i,
  input  logic [AW-1:0] adr_i,
  input  logic [DW-1:0] dat_i,
  output logic [DW-1:0] dat_o,
  output logic          ack_o,
  output logic [DW-1:0] cfg_o,
  output logic          cfg_wr_o,
  input  logic [SW-1:0] smp_i,
  input  logic          new_i,
  output logic          smp_rd_o
);
  localparam logic [DW-1:0] USED_MASK = DW'((1 << UW) - 1);

  logic [DW-1:0] cfg_q;
  logic [DW-1:0] rdat_q;
  logic [DW-1:0] rmux;
  logic          ack_q;
  logic          served_q;
  logic          accept;
  word_e         word;

  assign word   = word_e'(adr_i);
  assign accept = cyc_i & stb_i & ~ack_q & ~served_q;

  always_comb begin
    rmux = '0;
    unique case (word)
      W_CFG:   rmux = cfg_q;
      W_SMP:   begin
        rmux[SW-1:0] = smp_i;
        rmux[DW-1]   = new_i;
      end
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= RST_VAL & USED_MASK;
      rdat_q   <= '0;
      ack_q    <= 1'b0;
      served_q <= 1'b0;
    end else begin
      ack_q    <= accept;
      served_q <= stb_i & (served_q | accept);
      if (accept) begin
        if (we_i) begin
          if (word == W_CFG) cfg_q <= dat_i & USED_MASK;
          rdat_q <= '0;
        end else begin
          rdat_q <= rmux;
        end
      end
    end
  end

  assign dat_o    = rdat_q;
  assign ack_o    = ack_q;
  assign cfg_o    = cfg_q;
  assign cfg_wr_o = accept & we_i & (word == W_CFG);
  assign smp_rd_o = accept & ~we_i & (word == W_SMP);

  p_ack_once_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |=> !ack_q);
  p_ack_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |-> $past(cyc_i && stb_i));
  p_no_reack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (served_q && stb_i) |=> !ack_q);
  p_hi_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q & ~USED_MASK) == '0);
  p_res_wr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && we_i && word != W_CFG) |=> $stable(cfg_q));
endmodule

// File: rtl/adc_frontend_ctrl.sv
module adc_frontend_ctrl
  import adc_fe_pkg::*;
#(
  parameter int unsigned DW = BUS_W,
  parameter int unsigned AW = ADR_W,
  parameter int unsigned SW = SMP_W,
  parameter int unsigned PW = PRE_W,
  parameter logic [DW-1:0] RST_VAL = CFG_RST
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cyc_i,
  input  logic          stb_i,
  input  logic          we_i,
  input  logic [AW-1:0] adr_i,
  input  logic [DW-1:0] dat_i,
  output logic [DW-1:0] dat_o,
  output logic          ack_o,
  input  logic [SW-1:0] adc_data_i,
  output logic          adc_clk_o,
  output logic          adc_sleep_o,
  output logic          adc_cs_o
);
  localparam int unsigned EN_B  = PW;
  localparam int unsigned SLP_B = PW + 1;
  localparam int unsigned CS_B  = PW + 2;
  localparam int unsigned UW    = PW + 3;

  logic [DW-1:0] cfg;
  logic          cfg_wr;
  logic          smp_rd;
  logic          rise;
  logic          smp_new;
  logic [SW-1:0] smp;

  adc_fe_regs #(
    .DW(DW), .AW(AW), .SW(SW), .UW(UW), .RST_VAL(RST_VAL)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cyc_i    (cyc_i),
    .stb_i    (stb_i),
    .we_i     (we_i),
    .adr_i    (adr_i),
    .dat_i    (dat_i),
    .dat_o    (dat_o),
    .ack_o    (ack_o),
    .cfg_o    (cfg),
    .cfg_wr_o (cfg_wr),
    .smp_i    (smp),
    .new_i    (smp_new),
    .smp_rd_o (smp_rd)
  );

  adc_fe_clkdiv #(.PW(PW)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (cfg[EN_B]),
    .pre_i     (cfg[PW-1:0]),
    .restart_i (cfg_wr),
    .adc_clk_o (adc_clk_o),
    .rise_o    (rise)
  );

  adc_fe_capture #(.SW(SW)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (rise),
    .clr_i      (smp_rd),
    .adc_data_i (adc_data_i),
    .smp_o      (smp),
    .new_o      (smp_new)
  );

  assign adc_sleep_o = cfg[SLP_B];
  assign adc_cs_o    = cfg[CS_B];
endmodule

// File: tb/adc_frontend_ctrl_tb.sv
`timescale 1ns/1ps
module adc_frontend_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [1:0]  adr = '0;
  logic [15:0] wdat = '0;
  logic [15:0] rdat;
  logic        ack;
  logic [9:0]  adata = '0;
  logic        aclk, asleep, acs;
  int          errors = 0;
  int          checks = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  adc_frontend_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cyc_i(cyc), .stb_i(stb), .we_i(we),
    .adr_i(adr), .dat_i(wdat), .dat_o(rdat), .ack_o(ack),
    .adc_data_i(adata), .adc_clk_o(aclk), .adc_sleep_o(asleep), .adc_cs_o(acs)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cyc = 1; stb = 1; we = 1; adr = a; wdat = d;
    @(negedge clk);
    chk("R2 write ack", ack, 1);
    cyc = 0; stb = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    cyc = 1; stb = 1; we = 0; adr = a;
    @(negedge clk);
    chk("R2 read ack", ack, 1);
    d = rdat;
    cyc = 0; stb = 0;
  endtask

  task automatic measure(input string tag, input longint per_ps, input longint hi_ps);
    realtime t0, t1, t2;
    @(posedge aclk); t0 = $realtime;
    @(negedge aclk); t1 = $realtime;
    @(posedge aclk); t2 = $realtime;
    chk({tag, " period"}, longint'((t2 - t0) * 1000.0), per_ps);
    chk({tag, " high"},   longint'((t1 - t0) * 1000.0), hi_ps);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    chk("R1 ack at reset", ack, 0);
    rst_n = 1;
    chk("R1 sleep reset", asleep, 0);
    chk("R1 cs reset", acs, 1);
    bus_rd(2'd0, d);
    chk("R1 cfg reset", d, 16'h0A00);
    measure("R1 R5 reset divider", 10000, 5000);

    // R2: STB held past ACK
    @(negedge clk);
    cyc = 1; stb = 1; we = 0; adr = 2'd0;
    @(negedge clk);
    chk("R2 first ack", ack, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 no re-ack while STB held", ack, 0);
    end
    cyc = 0; stb = 0;
    @(negedge clk);
    chk("R2 idle", ack, 0);

    // R3, R4, R6: upper bits ignored, bypass
    bus_wr(2'd0, 16'hF5A5);
    bus_rd(2'd0, d);
    chk("R3 upper bits dropped", d, 16'h05A5);
    chk("R6 sleep bit10", asleep, 1);
    chk("R6 cs bit11", acs, 0);
    measure("R4 bypass", 5000, 2500);

    // R6: all pin combinations
    for (int k = 0; k < 4; k++) begin
      bus_wr(2'd0, 16'h0200 | 16'(k << 10));
      @(negedge clk);
      chk("R6 sleep", asleep, k & 1);
      chk("R6 cs", acs, (k >> 1) & 1);
    end

    // R5: divider sweep
    for (int p = 0; p < 16; p++) begin
      bus_wr(2'd0, 16'h0A00 | 16'(p));
      measure("R5 divided", 10000 * (p + 1), 5000 * (p + 1));
    end
    bus_wr(2'd0, 16'h0BFF);
    measure("R5 prescaler 511", 10000 * 512, 5000 * 512);

    // R11: restart on write
    bus_wr(2'd0, 16'h0A04);
    chk("R11 low after write", aclk, 0);
    repeat (4) @(negedge clk);
    chk("R11 still low at P", aclk, 0);
    @(negedge clk);
    chk("R11 rises at P+1", aclk, 1);

    // R10: reserved words
    bus_wr(2'd2, 16'h0123);
    bus_wr(2'd3, 16'h0FFF);
    bus_rd(2'd0, d);
    chk("R10 cfg unchanged", d, 16'h0A04);
    bus_rd(2'd2, d);
    chk("R10 word2 zero", d, 0);
    bus_rd(2'd3, d);
    chk("R10 word3 zero", d, 0);

    // R7, R8, R9: capture timing with slow converter clock
    bus_wr(2'd0, 16'h0BFF);
    @(posedge aclk);
    @(negedge clk); adata = 10'h2B5;
    @(negedge clk); adata = 10'h14A;
    bus_rd(2'd1, d);
    chk("R7 R9 sample with flag", d, 16'h82B5);
    bus_rd(2'd1, d);
    chk("R8 flag cleared", d, 16'h02B5);
    @(posedge aclk);
    repeat (2) @(negedge clk);
    bus_rd(2'd1, d);
    chk("R8 flag set again", d, 16'h814A);

    done = 1;
    report();
    $finish;
  end
endmodule